// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the processor-facing register file of a 16550-compatible asynchronous serial controller. It sits on a byte-wide bus with a 3-bit offset, a write strobe and a read strobe. It stores the interrupt enable bits, the line format, the modem control outputs, the FIFO settings and the 16-bit baud divisor. It steers each access to the right register or neighbouring unit. Setting bit 7 of the line control register switches offsets 0 and 1 from the data port and the interrupt enable register to the two divisor bytes. Software loads the divisor with the input clock frequency divided by sixteen times the baud rate.

The serial shifters, the FIFOs and the interrupt prioritiser live outside this block. They supply the head of the receive FIFO, the interrupt identity code and the line and modem status bytes through input ports. In return the block drives a receive-pop strobe, a transmit-push strobe with its byte, one-cycle FIFO clear pulses, and the held configuration fields.

Top module: `uart_regbank`

## Requirements
- R1: After synchronous reset, the interrupt enables, all line control fields, all modem outputs, the divisor, the FIFO enable, the DMA mode bit and the trigger code are zero. Reading offset 3 returns 0x00.
- R2: While line control bit 7 is clear, a read at offset 0 returns `rx_data` and raises `rx_pop` in that same cycle. A write at offset 0 raises `tx_push` with `tx_data` equal to the written byte. A write at offset 1 stores bits 3:0 as `irq_en`, and a read of offset 1 returns those bits with bits 7:4 as zero.
- R3: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. These accesses never raise `rx_pop` or `tx_push` and leave `irq_en` unchanged.
- R4: A write at offset 3 sets the line fields from the next clock edge: bits 1:0 word-length code (00 selects 5 bits up to 11 for 8 bits), bit 2 two stop bits, bit 3 parity enable, bit 4 even parity, bit 5 stick parity, bit 6 break, and bit 7 divisor access. Offset 3 reads back all eight bits.
- R5: A write at offset 2 holds bit 0 as `fifo_en`, bit 3 as `dma_mode1` and bits 7:6 as `rx_trig`. Bit 1 produces a one-cycle `rx_fifo_clr` pulse and bit 2 produces a one-cycle `tx_fifo_clr` pulse, each in the cycle after the write. The clear bits are not stored.
- R6: A read at offset 2 returns `fifo_en` in both bit 7 and bit 6, zero in bits 5:4 and `irq_id` in bits 3:0.
- R7: A write at offset 4 drives bit 0 to `dtr`, bit 1 to `rts`, bit 2 to `out1`, bit 3 to `out2` and bit 4 to `loopback`. Offset 4 reads back those five bits with bits 7:5 as zero.
- R8: Reads at offsets 5 and 6 return `line_status` and `modem_status`, and a read at offset 7 returns zero. Writes at offsets 5, 6 and 7 change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from offset |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Pops the receive FIFO |
| tx_data | output | 8 | Byte for the transmit FIFO |
| tx_push | output | 1 | Pushes `tx_data` into the transmit FIFO |
| irq_id | input | 4 | Identity code from the interrupt prioritiser |
| line_status | input | 8 | Line status byte |
| modem_status | input | 8 | Modem status byte |
| irq_en | output | 4 | Interrupt enable bits |
| word_len | output | 2 | Data bits code, 0 to 3 for 5 to 8 bits |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enable |
| even_parity | output | 1 | Even parity select |
| stick_parity | output | 1 | Stick parity select |
| break_ctl | output | 1 | Force line to spacing |
| divisor | output | 16 | Baud divisor |
| fifo_en | output | 1 | FIFOs enabled |
| dma_mode1 | output | 1 | DMA signalling mode 1 |
| rx_trig | output | 2 | Receive trigger code (1, 4, 8, 14 bytes) |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| dtr | output | 1 | Data terminal ready output |
| rts | output | 1 | Request to send output |
| out1 | output | 1 | General output 1 |
| out2 | output | 1 | General output 2 |
| loopback | output | 1 | Loopback enable |

## Verification
The properties assume that a host never raises the read and write strobes together and holds the offset and data steady while a strobe is high. They also assume each write strobe lasts a single cycle, so one FIFO command gives exactly one clear pulse. The stimulus drives every access from the falling clock edge, raises one strobe at a time for one cycle, and returns both strobes low between accesses. It samples the combinational read data and the push and pop strobes inside that same cycle.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int IER_W     = 4;
    localparam int MCR_W     = 5;
    localparam int DIV_BYTES = 2;
    localparam int DIV_W     = DIV_BYTES * DATA_W;
    localparam int IID_W     = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IER   = 3'd1,
        OFS_IID   = 3'd2,
        OFS_LINE  = 3'd3,
        OFS_MODEM = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SPARE = 3'd7
    } reg_ofs_e;

    // Field order mirrors the bit positions software writes (MSB first).
    typedef struct packed {
        logic       dlab;
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_cfg_t;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } modem_cfg_t;

    typedef struct packed {
        logic [1:0] trig;
        logic [1:0] rsvd;
        logic       dma1;
        logic       tx_clr;
        logic       rx_clr;
        logic       en;
    } fifo_cmd_t;

    typedef struct packed {
        logic                wr_data;
        logic                wr_ier;
        logic                wr_fifo;
        logic                wr_line;
        logic                wr_modem;
        logic [DIV_BYTES-1:0] wr_div;
        logic                rd_data;
    } strobe_t;

    function automatic logic [DATA_W-1:0] iid_byte(input logic fen, input logic [IID_W-1:0] id);
        return {fen, fen, 2'b00, id};
    endfunction

endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uart_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              dlab,
    output strobe_t           st
);
    always_comb begin
        st = '0;
        if (wr) begin
            case (addr)
                OFS_DATA:  if (dlab) st.wr_div[0] = 1'b1; else st.wr_data = 1'b1;
                OFS_IER:   if (dlab) st.wr_div[1] = 1'b1; else st.wr_ier  = 1'b1;
                OFS_IID:   st.wr_fifo  = 1'b1;
                OFS_LINE:  st.wr_line  = 1'b1;
                OFS_MODEM: st.wr_modem = 1'b1;
                default:   ;
            endcase
        end
        if (rd && (addr == OFS_DATA) && !dlab)
            st.rd_data = 1'b1;
    end
endmodule

// File: rtl/uart_divisor_latch.sv
module uart_divisor_latch
    import uart_regbank_pkg::*;
#(
    parameter int NBYTES = DIV_BYTES,
    parameter int BYTE_W = DATA_W,
    localparam int OUT_W = NBYTES * BYTE_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [NBYTES-1:0] wr_byte,
    input  logic [BYTE_W-1:0] wdata,
    output logic [OUT_W-1:0]  value
);
    logic [BYTE_W-1:0] bytes_q [NBYTES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bytes_q[b] <= '0;
            else if (wr_byte[b])
                bytes_q[b] <= wdata;
        end
        assign value[b*BYTE_W +: BYTE_W] = bytes_q[b];
    end
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       en_bit,
    input  logic       dma_bit,
    input  logic [1:0] trig_bits,
    input  logic       rx_clr_bit,
    input  logic       tx_clr_bit,
    output logic       fifo_en,
    output logic       dma_mode1,
    output logic [1:0] rx_trig,
    output logic       rx_clr,
    output logic       tx_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en   <= 1'b0;
            dma_mode1 <= 1'b0;
            rx_trig   <= 2'b00;
            rx_clr    <= 1'b0;
            tx_clr    <= 1'b0;
        end else begin
            rx_clr <= wr & rx_clr_bit;
            tx_clr <= wr & tx_clr_bit;
            if (wr) begin
                fifo_en   <= en_bit;
                dma_mode1 <= dma_bit;
                rx_trig   <= trig_bits;
            end
        end
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  rx_data,
    output logic        rx_pop,
    output logic [7:0]  tx_data,
    output logic        tx_push,
    input  logic [3:0]  irq_id,
    input  logic [7:0]  line_status,
    input  logic [7:0]  modem_status,
    output logic [3:0]  irq_en,
    output logic [1:0]  word_len,
    output logic        two_stop,
    output logic        parity_en,
    output logic        even_parity,
    output logic        stick_parity,
    output logic        break_ctl,
    output logic [15:0] divisor,
    output logic        fifo_en,
    output logic        dma_mode1,
    output logic [1:0]  rx_trig,
    output logic        rx_fifo_clr,
    output logic        tx_fifo_clr,
    output logic        dtr,
    output logic        rts,
    output logic        out1,
    output logic        out2,
    output logic        loopback
);
    line_cfg_t       lcr_q;
    modem_cfg_t      mcr_q;
    logic [IER_W-1:0] ier_q;
    strobe_t         st;
    fifo_cmd_t       fcmd;

    assign fcmd = fifo_cmd_t'(bus_wdata);

    uart_addr_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .dlab (lcr_q.dlab),
        .st   (st)
    );

    uart_divisor_latch u_div (
        .clk     (clk),
        .rst     (rst),
        .wr_byte (st.wr_div),
        .wdata   (bus_wdata),
        .value   (divisor)
    );

    uart_fifo_ctrl u_fifo (
        .clk        (clk),
        .rst        (rst),
        .wr         (st.wr_fifo),
        .en_bit     (fcmd.en),
        .dma_bit    (fcmd.dma1),
        .trig_bits  (fcmd.trig),
        .rx_clr_bit (fcmd.rx_clr),
        .tx_clr_bit (fcmd.tx_clr),
        .fifo_en    (fifo_en),
        .dma_mode1  (dma_mode1),
        .rx_trig    (rx_trig),
        .rx_clr     (rx_fifo_clr),
        .tx_clr     (tx_fifo_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q <= '0;
            mcr_q <= '0;
            ier_q <= '0;
        end else begin
            if (st.wr_line)  lcr_q <= line_cfg_t'(bus_wdata);
            if (st.wr_modem) mcr_q <= modem_cfg_t'(bus_wdata[MCR_W-1:0]);
            if (st.wr_ier)   ier_q <= bus_wdata[IER_W-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA:  bus_rdata = lcr_q.dlab ? divisor[DATA_W-1:0] : rx_data;
            OFS_IER:   bus_rdata = lcr_q.dlab ? divisor[DIV_W-1:DATA_W]
                                              : {{(DATA_W-IER_W){1'b0}}, ier_q};
            OFS_IID:   bus_rdata = iid_byte(fifo_en, irq_id);
            OFS_LINE:  bus_rdata = lcr_q;
            OFS_MODEM: bus_rdata = {{(DATA_W-MCR_W){1'b0}}, mcr_q};
            OFS_LSTAT: bus_rdata = line_status;
            OFS_MSTAT: bus_rdata = modem_status;
            default:   bus_rdata = '0;
        endcase
    end

    assign rx_pop       = st.rd_data;
    assign tx_push      = st.wr_data;
    assign tx_data      = bus_wdata;
    assign irq_en       = ier_q;
    assign word_len     = lcr_q.wlen;
    assign two_stop     = lcr_q.two_stop;
    assign parity_en    = lcr_q.par_en;
    assign even_parity  = lcr_q.even;
    assign stick_parity = lcr_q.stick;
    assign break_ctl    = lcr_q.brk;
    assign dtr          = mcr_q.dtr;
    assign rts          = mcr_q.rts;
    assign out1         = mcr_q.out1;
    assign out2         = mcr_q.out2;
    assign loopback     = mcr_q.loop;
endmodule

// File: rtl/uart_regbank_checker.sv
module uart_regbank_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata,
    input logic        dlab,
    input logic        rx_pop,
    input logic        tx_push,
    input logic        rx_fifo_clr,
    input logic [1:0]  word_len,
    input logic [15:0] divisor
);
    // R3: divisor access mode never touches the FIFOs
    a_r3_no_pop_in_latch_mode: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> !dlab);
    a_r3_no_push_in_latch_mode: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> !dlab);
    // R3: divisor only moves on a latch-mode write to offset 0 or 1
    a_r3_divisor_holds: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && dlab && (bus_addr <= 3'd1)) |=> $stable(divisor));
    // R4: word length follows the last line control write
    a_r4_wlen_follows_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3) |=> (word_len == $past(bus_wdata[1:0])));
    // R5: a receive clear pulse always traces back to a FIFO command write
    a_r5_rx_clear_from_cmd: assert property (@(posedge clk) disable iff (rst)
        rx_fifo_clr |-> $past(bus_wr && bus_addr == 3'd2 && bus_wdata[1]));
    // R2: interrupt enable readback keeps the upper nibble at zero
    a_r2_ier_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd1 && !dlab) |-> (bus_rdata[7:4] == 4'h0));
endmodule

bind uart_regbank uart_regbank_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .dlab        (lcr_q.dlab),
    .rx_pop      (rx_pop),
    .tx_push     (tx_push),
    .rx_fifo_clr (rx_fifo_clr),
    .word_len    (word_len),
    .divisor     (divisor)
);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  rx_data = 8'hA5;
    logic        rx_pop;
    logic [7:0]  tx_data;
    logic        tx_push;
    logic [3:0]  irq_id = 4'h4;
    logic [7:0]  line_status = 8'h61;
    logic [7:0]  modem_status = 8'hB3;
    logic [3:0]  irq_en;
    logic [1:0]  word_len;
    logic        two_stop, parity_en, even_parity, stick_parity, break_ctl;
    logic [15:0] divisor;
    logic        fifo_en, dma_mode1;
    logic [1:0]  rx_trig;
    logic        rx_fifo_clr, tx_fifo_clr;
    logic        dtr, rts, out1, out2, loopback;

    int n_checks = 0;
    int n_fail = 0;
    logic       push_seen, clr_rx_seen, clr_tx_seen;
    logic [7:0] push_byte;
    logic [7:0] rd_val;
    logic       pop_seen;

    always #4 clk = ~clk;

    uart_regbank uut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FIAL_MARK");
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        push_seen = tx_push; push_byte = tx_data;
        @(negedge clk);
        bus_wr = 1'b0;
        clr_rx_seen = rx_fifo_clr; clr_tx_seen = tx_fifo_clr;
    endtask

    task automatic rd_reg(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        rd_val = bus_rdata; pop_seen = rx_pop;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq_en", irq_en, 0);
        check("R1 line fields", {word_len, two_stop, parity_en, even_parity, stick_parity, break_ctl}, 0);
        check("R1 divisor", divisor, 0);
        check("R1 fifo fields", {fifo_en, dma_mode1, rx_trig}, 0);
        check("R1 modem outs", {dtr, rts, out1, out2, loopback}, 0);
        rd_reg(3'd3); check("R1 line readback", rd_val, 8'h00);
    endtask

    task automatic t_line();
        wr_reg(3'd3, 8'h3B);
        check("R4 wlen", word_len, 2'd3);
        check("R4 par/even/stick/stop/brk", {parity_en, even_parity, stick_parity, two_stop, break_ctl}, 5'b11100);
        rd_reg(3'd3); check("R4 readback", rd_val, 8'h3B);
        wr_reg(3'd3, 8'h44);
        check("R4 wlen 5 bits", word_len, 2'd0);
        check("R4 stop/brk", {two_stop, break_ctl, parity_en}, 3'b110);
        wr_reg(3'd3, 8'h03);
    endtask

    task automatic t_data();
        wr_reg(3'd1, 8'hFF);
        check("R2 irq_en", irq_en, 4'hF);
        rd_reg(3'd1); check("R2 ier readback", rd_val, 8'h0F);
        wr_reg(3'd0, 8'h5C);
        check("R2 tx push", push_seen, 1'b1);
        check("R2 tx byte", push_byte, 8'h5C);
        rd_reg(3'd0);
        check("R2 rx byte", rd_val, 8'hA5);
        check("R2 rx pop", pop_seen, 1'b1);
    endtask

    task automatic t_divisor();
        wr_reg(3'd3, 8'h83);
        wr_reg(3'd0, 8'h34);
        check("R3 no push", push_seen, 1'b0);
        wr_reg(3'd1, 8'h12);
        check("R3 divisor", divisor, 16'h1234);
        check("R3 irq_en untouched", irq_en, 4'hF);
        rd_reg(3'd0);
        check("R3 low byte", rd_val, 8'h34);
        check("R3 no pop", pop_seen, 1'b0);
        rd_reg(3'd1); check("R3 high byte", rd_val, 8'h12);
        wr_reg(3'd3, 8'h03);
        rd_reg(3'd1); check("R3 ier back after clear", rd_val, 8'h0F);
        check("R3 divisor kept", divisor, 16'h1234);
    endtask

    task automatic t_fifo();
        wr_reg(3'd2, 8'hC9);
        check("R5 en/dma/trig", {fifo_en, dma_mode1, rx_trig}, 4'b1111);
        check("R5 no clears", {clr_rx_seen, clr_tx_seen}, 2'b00);
        rd_reg(3'd2); check("R6 iid enabled", rd_val, 8'hC4);
        wr_reg(3'd2, 8'h87);
        check("R5 both clears", {clr_rx_seen, clr_tx_seen}, 2'b11);
        check("R5 held fields", {fifo_en, dma_mode1, rx_trig}, 4'b1010);
        @(negedge clk);
        check("R5 clears one cycle", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
        wr_reg(3'd2, 8'h02);
        check("R5 rx clear only", {clr_rx_seen, clr_tx_seen}, 2'b10);
        check("R5 fifo disabled", fifo_en, 1'b0);
        rd_reg(3'd2); check("R6 iid disabled", rd_val, 8'h04);
    endtask

    task automatic t_modem();
        wr_reg(3'd4, 8'hFF);
        check("R7 all outs", {dtr, rts, out1, out2, loopback}, 5'b11111);
        rd_reg(3'd4); check("R7 readback", rd_val, 8'h1F);
        wr_reg(3'd4, 8'h0A);
        check("R7 rts/out2", {dtr, rts, out1, out2, loopback}, 5'b01010);
    endtask

    task automatic t_status();
        rd_reg(3'd5); check("R8 line status", rd_val, 8'h61);
        rd_reg(3'd6); check("R8 modem status", rd_val, 8'hB3);
        rd_reg(3'd7); check("R8 spare zero", rd_val, 8'h00);
        wr_reg(3'd5, 8'hFF);
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd7, 8'hFF);
        check("R8 writes ignored modem", {dtr, rts, out1, out2, loopback}, 5'b01010);
        check("R8 writes ignored ier", irq_en, 4'hF);
        check("R8 writes ignored div", divisor, 16'h1234);
        rd_reg(3'd3); check("R8 writes ignored line", rd_val, 8'h03);
        rd_reg(3'd7); check("R8 spare still zero", rd_val, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_line();
        t_data();
        t_divisor();
        t_fifo();
        t_modem();
        t_status();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule